// File: doc/BRIEF.md
# Register Command Frame Receiver (2-bit RMII)

This block sits on the receive side of a 2-bit RMII link and turns small Ethernet frames into register access commands. It samples the carrier/data-valid line and the two receive data bits once per reference clock. It rebuilds bytes from the dibits, waits for the preamble and start delimiter, and then walks the frame as a byte stream. It checks the destination address and the EtherType against parameters as the bytes go by, and it keeps a running CRC-32 over the frame.

The first five payload bytes carry a command. The first is a code byte (0x00 read, 0x01 write). The next two are a 16-bit register address and the last two are 16-bit write data, both with the high byte first. All bytes after these, up to the frame check sequence, are padding and are discarded. When the carrier drops, the frame is judged as a whole. If it passes every check, the decoded command appears on the outputs together with a single-cycle valid strobe. The outputs then hold their values until the next accepted frame.

Top module: `rmii_cmd_rx`

## Requirements
- R1: While reset is asserted and right after it is released, cmd_valid, cmd_write, cmd_addr and cmd_wdata are all zero.
- R2: Each rxd dibit is taken least significant bit first, and four dibits make one byte. Byte capture starts only after a 0x55 byte directly followed by 0xD5, both seen while crs_dv is high. A frame without that pair never produces a command.
- R3: A frame is accepted only if its first six bytes equal parameter STATION_ADDR, most significant byte first on the wire (default 12:34:56:78:9A:BC).
- R4: A frame is accepted only if bytes 12 and 13 equal parameter FRAME_TYPE, high byte first (default 0x88B5).
- R5: Payload byte 0 (frame byte 14) is the command code. 0x00 gives cmd_write=0 and 0x01 gives cmd_write=1. Any other code drops the frame.
- R6: Payload bytes 1 and 2 form cmd_addr, with byte 1 as bits 15:8.
- R7: For a write, payload bytes 3 and 4 form cmd_wdata, with byte 3 as bits 15:8. For a read these bytes are ignored and cmd_wdata is presented as zero.
- R8: The CRC-32 (reflected polynomial 0xEDB88320, seed all ones) runs over every byte from the destination address through the four frame check bytes. A frame is accepted only if the register then holds the residue 0xDEBB20E3.
- R9: Zero padding after the command is accepted and discarded. A frame shorter than MIN_FRAME_BYTES (default 64, counting address through check bytes) is dropped, and so is a frame whose carrier ends partway through a byte.
- R10: Each accepted frame raises cmd_valid for exactly one clock, two clocks after the first clock edge that samples crs_dv low.
- R11: cmd_write, cmd_addr and cmd_wdata change only in the cycle cmd_valid is high. A dropped frame leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive reference clock, one dibit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| crs_dv | input | 1 | Carrier sense / receive data valid |
| rxd | input | 2 | Receive dibit |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_write | output | 1 | 1 for write, 0 for read |
| cmd_addr | output | 16 | Register address |
| cmd_wdata | output | 16 | Write data, zero for reads |

## Verification
Most internal faults in this block appear at the ports as a missing strobe at the end of the frame, about two clocks after the carrier falls. A slipped dibit phase, a stale CRC register, a header flag that was never cleared, or a wrong byte index all drop the next good frame. A wrong capture index instead gives a strobe whose address or data fields hold a shifted or swapped value, which shows on the very next accepted command. Faults that accept too much can only be seen with dropped frames. For that reason the sweeps send frames that are each one field away from valid and confirm that the held outputs do not move.

// File: rtl/rmii_cmd_pkg.sv
package rmii_cmd_pkg;

  localparam logic [7:0]  PREAMBLE_BYTE   = 8'h55;
  localparam logic [7:0]  SYNC_BYTE       = 8'hD5;
  localparam logic [15:0] SYNC_WINDOW     = {SYNC_BYTE, PREAMBLE_BYTE};

  localparam logic [31:0] CRC_POLY_REFL   = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED        = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE     = 32'hDEBB_20E3;

  localparam int          ADDR_BYTES      = 6;
  localparam int          TYPE_OFFSET     = 12;
  localparam int          HDR_BYTES       = 14;

  localparam logic [7:0]  CODE_READ       = 8'h00;
  localparam logic [7:0]  CODE_WRITE      = 8'h01;

  typedef struct packed {
    logic        write;
    logic [15:0] addr;
    logic [15:0] wdata;
  } reg_cmd_t;

  typedef struct packed {
    logic       care;
    logic [7:0] value;
  } hdr_expect_t;

  // One byte of reflected CRC-32, data taken LSB first.
  function automatic logic [31:0] crc32_byte_step(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
    logic [31:0] c;
    c = crc_in ^ {24'h0, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

  // Expected header byte at a given frame index; care=0 where any value passes.
  function automatic hdr_expect_t hdr_expect(input logic [47:0] station,
                                             input logic [15:0] ftype,
                                             input logic [15:0] idx);
    hdr_expect_t e;
    e.care  = 1'b1;
    e.value = 8'h00;
    case (idx)
      16'd0:  e.value = station[47:40];
      16'd1:  e.value = station[39:32];
      16'd2:  e.value = station[31:24];
      16'd3:  e.value = station[23:16];
      16'd4:  e.value = station[15:8];
      16'd5:  e.value = station[7:0];
      16'd12: e.value = ftype[15:8];
      16'd13: e.value = ftype[7:0];
      default: e.care = 1'b0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/rmii_dibit_framer.sv
module rmii_dibit_framer
  import rmii_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  output logic       byte_stb,
  output logic [7:0] byte_dat,
  output logic       sof,
  output logic       eof,
  output logic       eof_aligned
);

  logic [15:0] win_q;
  logic [15:0] win_next;
  logic [1:0]  phase_q;
  logic        in_frame_q;
  logic        sync_hit;

  // newest dibit enters at the top, so after four dibits a byte sits LSB-first
  assign win_next = {rxd, win_q[15:2]};
  assign sync_hit = crs_dv && !in_frame_q && (win_next == SYNC_WINDOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q       <= '0;
      phase_q     <= '0;
      in_frame_q  <= 1'b0;
      byte_stb    <= 1'b0;
      byte_dat    <= '0;
      sof         <= 1'b0;
      eof         <= 1'b0;
      eof_aligned <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      sof      <= 1'b0;
      eof      <= 1'b0;
      if (!crs_dv) begin
        win_q   <= '0;
        phase_q <= '0;
        if (in_frame_q) begin
          eof         <= 1'b1;
          eof_aligned <= (phase_q == 2'd0);
        end
        in_frame_q <= 1'b0;
      end else if (!in_frame_q) begin
        win_q <= win_next;
        if (sync_hit) begin
          in_frame_q <= 1'b1;
          sof        <= 1'b1;
          phase_q    <= '0;
        end
      end else begin
        win_q   <= win_next;
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd3) begin
          byte_stb <= 1'b1;
          byte_dat <= win_next[15:8];
        end
      end
    end
  end

  a_r2_sof_needs_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> $past(crs_dv));
  a_r2_byte_needs_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(crs_dv));
  a_r9_eof_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !$past(crs_dv));
  a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof, eof, byte_stb}));

endmodule

// File: rtl/rmii_fcs_check.sv
module rmii_fcs_check
  import rmii_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       step,
  input  logic [7:0] data,
  output logic       crc_ok
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (clear) begin
      crc_q <= CRC_SEED;
    end else if (step) begin
      crc_q <= crc32_byte_step(crc_q, data);
    end
  end

  assign crc_ok = (crc_q == CRC_RESIDUE);

  a_r8_seed_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == CRC_SEED));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !step) |=> $stable(crc_q));

endmodule

// File: rtl/rmii_cmd_decode.sv
module rmii_cmd_decode
  import rmii_cmd_pkg::*;
#(
  parameter logic [47:0] STATION_ADDR    = 48'h12_34_56_78_9A_BC,
  parameter logic [15:0] FRAME_TYPE      = 16'h88B5,
  parameter int          MIN_FRAME_BYTES = 64,
  parameter int          IDX_W           = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof,
  input  logic       byte_stb,
  input  logic [7:0] byte_dat,
  input  logic       eof,
  input  logic       eof_aligned,
  input  logic       crc_ok,
  output logic       fcs_clear,
  output logic       fcs_step,
  output logic       cmd_valid,
  output reg_cmd_t   cmd_q
);

  localparam logic [IDX_W-1:0] IDX_CODE  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_AHI   = IDX_W'(HDR_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_ALO   = IDX_W'(HDR_BYTES + 2);
  localparam logic [IDX_W-1:0] IDX_DHI   = IDX_W'(HDR_BYTES + 3);
  localparam logic [IDX_W-1:0] IDX_DLO   = IDX_W'(HDR_BYTES + 4);
  localparam logic [IDX_W-1:0] IDX_MIN   = IDX_W'(MIN_FRAME_BYTES);
  localparam logic [IDX_W-1:0] IDX_MAX   = {IDX_W{1'b1}};

  logic             active_q;
  logic             hdr_hit_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       code_q;
  logic [15:0]      addr_s;
  logic [15:0]      data_s;

  hdr_expect_t      exp_b;
  logic             byte_mismatch;
  logic             long_enough;
  logic             code_known;
  logic             accept;

  assign exp_b         = hdr_expect(STATION_ADDR, FRAME_TYPE, 16'(idx_q));
  assign byte_mismatch = exp_b.care && (byte_dat != exp_b.value);
  assign long_enough   = (idx_q >= IDX_MIN);
  assign code_known    = (code_q == CODE_READ) || (code_q == CODE_WRITE);
  assign accept        = eof && active_q && eof_aligned && hdr_hit_q &&
                         crc_ok && long_enough && code_known;

  assign fcs_clear = sof;
  assign fcs_step  = byte_stb && active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      hdr_hit_q <= 1'b0;
      idx_q     <= '0;
      code_q    <= 8'hFF;
      addr_s    <= '0;
      data_s    <= '0;
    end else if (sof) begin
      active_q  <= 1'b1;
      hdr_hit_q <= 1'b1;
      idx_q     <= '0;
      code_q    <= 8'hFF;
    end else if (fcs_step) begin
      if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      if (byte_mismatch) hdr_hit_q <= 1'b0;
      if (idx_q == IDX_CODE) code_q        <= byte_dat;
      if (idx_q == IDX_AHI)  addr_s[15:8]  <= byte_dat;
      if (idx_q == IDX_ALO)  addr_s[7:0]   <= byte_dat;
      if (idx_q == IDX_DHI)  data_s[15:8]  <= byte_dat;
      if (idx_q == IDX_DLO)  data_s[7:0]   <= byte_dat;
    end else if (eof) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_q     <= '0;
    end else begin
      cmd_valid <= accept;
      if (accept) begin
        cmd_q.write <= (code_q == CODE_WRITE);
        cmd_q.addr  <= addr_s;
        cmd_q.wdata <= (code_q == CODE_WRITE) ? data_s : 16'h0000;
      end
    end
  end

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_q));
  a_r8_strobe_needs_crc: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(crc_ok));
  a_r9_strobe_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(idx_q) >= IDX_MIN));
  a_r5_strobe_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(code_q) <= CODE_WRITE));
  a_r3_strobe_needs_header: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(hdr_hit_q));
  a_r7_read_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_q.write) |-> (cmd_q.wdata == 16'h0000));

endmodule

// File: rtl/rmii_cmd_rx.sv
module rmii_cmd_rx
  import rmii_cmd_pkg::*;
#(
  parameter logic [47:0] STATION_ADDR    = 48'h12_34_56_78_9A_BC,
  parameter logic [15:0] FRAME_TYPE      = 16'h88B5,
  parameter int          MIN_FRAME_BYTES = 64,
  parameter int          IDX_W           = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crs_dv,
  input  logic [1:0]  rxd,
  output logic        cmd_valid,
  output logic        cmd_write,
  output logic [15:0] cmd_addr,
  output logic [15:0] cmd_wdata
);

  logic       byte_stb;
  logic [7:0] byte_dat;
  logic       sof;
  logic       eof;
  logic       eof_aligned;
  logic       fcs_clear;
  logic       fcs_step;
  logic       crc_ok;
  reg_cmd_t   cmd_q;

  rmii_dibit_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .crs_dv      (crs_dv),
    .rxd         (rxd),
    .byte_stb    (byte_stb),
    .byte_dat    (byte_dat),
    .sof         (sof),
    .eof         (eof),
    .eof_aligned (eof_aligned)
  );

  rmii_fcs_check u_fcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (fcs_clear),
    .step   (fcs_step),
    .data   (byte_dat),
    .crc_ok (crc_ok)
  );

  rmii_cmd_decode #(
    .STATION_ADDR    (STATION_ADDR),
    .FRAME_TYPE      (FRAME_TYPE),
    .MIN_FRAME_BYTES (MIN_FRAME_BYTES),
    .IDX_W           (IDX_W)
  ) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof         (sof),
    .byte_stb    (byte_stb),
    .byte_dat    (byte_dat),
    .eof         (eof),
    .eof_aligned (eof_aligned),
    .crc_ok      (crc_ok),
    .fcs_clear   (fcs_clear),
    .fcs_step    (fcs_step),
    .cmd_valid   (cmd_valid),
    .cmd_q       (cmd_q)
  );

  assign cmd_write = cmd_q.write;
  assign cmd_addr  = cmd_q.addr;
  assign cmd_wdata = cmd_q.wdata;

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!cmd_valid && cmd_addr == 16'h0 && cmd_wdata == 16'h0 && !cmd_write));
  a_r10_strobe_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(crs_dv));

endmodule

// File: tb/rmii_cmd_rx_bench.sv
module rmii_cmd_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crs_dv = 1'b0;
  logic [1:0]  rxd = 2'b00;
  logic        cmd_valid;
  logic        cmd_write;
  logic [15:0] cmd_addr;
  logic [15:0] cmd_wdata;

  int total = 0;
  int bad   = 0;
  int pulses = 0;

  logic [7:0]  fb [0:255];
  int          flen;

  logic        exp_w = 1'b0;
  logic [15:0] exp_a = 16'h0;
  logic [15:0] exp_d = 16'h0;

  localparam logic [47:0] DEST  = 48'h12_34_56_78_9A_BC;
  localparam logic [15:0] ETYPE = 16'h88B5;

  always #5 clk = ~clk;

  rmii_cmd_rx u_rmii_cmd_rx (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata)
  );

  always @(negedge clk) if (rst_n && cmd_valid) pulses++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Bitwise reflected CRC, one data bit at a time.
  function automatic logic [31:0] ref_crc(input int len);
    logic [31:0] c;
    logic fbk;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      for (int j = 0; j < 8; j++) begin
        fbk = c[0] ^ fb[i][j];
        c = {1'b0, c[31:1]};
        if (fbk) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic build(input logic [47:0] da, input logic [15:0] et, input logic [7:0] code,
                       input logic [15:0] a, input logic [15:0] d, input int body, input bit bad_fcs);
    logic [31:0] fcs;
    for (int i = 0; i < 256; i++) fb[i] = 8'h00;
    for (int i = 0; i < 6; i++) fb[i] = da[8*(5-i) +: 8];
    for (int i = 6; i < 12; i++) fb[i] = 8'hA0 + 8'(i);
    fb[12] = et[15:8]; fb[13] = et[7:0];
    fb[14] = code; fb[15] = a[15:8]; fb[16] = a[7:0]; fb[17] = d[15:8]; fb[18] = d[7:0];
    fcs = ~ref_crc(body);
    if (bad_fcs) fcs = fcs ^ 32'h0000_0100;
    fb[body] = fcs[7:0]; fb[body+1] = fcs[15:8]; fb[body+2] = fcs[23:16]; fb[body+3] = fcs[31:24];
    flen = body + 4;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); crs_dv = 1'b1; rxd = b[2*k +: 2];
    end
  endtask

  // pre_mode: 0 normal, 1 delimiter without preamble, 2 preamble without delimiter
  task automatic send(input int pre_mode, input bit extra_dibit, input int gap);
    if (pre_mode == 0) begin
      for (int i = 0; i < 7; i++) put_byte(8'h55);
      put_byte(8'hD5);
    end else if (pre_mode == 1) begin
      put_byte(8'hD5);
    end else begin
      for (int i = 0; i < 8; i++) put_byte(8'h55);
    end
    for (int i = 0; i < flen; i++) put_byte(fb[i]);
    if (extra_dibit) begin @(negedge clk); rxd = 2'b10; end
    @(negedge clk); crs_dv = 1'b0; rxd = 2'b00;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_accept(input string tag);
    chk(pulses == 1, {tag, " strobe count"}, 32'(pulses), 32'd1);
    chk(cmd_write == exp_w, {tag, " cmd_write"}, 32'(cmd_write), 32'(exp_w));
    chk(cmd_addr == exp_a, {tag, " cmd_addr"}, 32'(cmd_addr), 32'(exp_a));
    chk(cmd_wdata == exp_d, {tag, " cmd_wdata"}, 32'(cmd_wdata), 32'(exp_d));
  endtask

  task automatic expect_drop(input string tag);
    chk(pulses == 0, {tag, " dropped"}, 32'(pulses), 32'd0);
    chk({cmd_write, cmd_addr, cmd_wdata} == {exp_w, exp_a, exp_d}, {tag, " R11 held"},
        {15'h0, cmd_write, cmd_addr}, {15'h0, exp_w, exp_a});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!cmd_valid && cmd_addr == 0 && cmd_wdata == 0 && !cmd_write, "R1 in reset",
        {cmd_addr, cmd_wdata}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!cmd_valid && cmd_addr == 0 && cmd_wdata == 0 && !cmd_write, "R1 after reset",
        {cmd_addr, cmd_wdata}, 32'h0);

    // R5 R6 R7 R10: write sweep
    for (int i = 0; i < 12; i++) begin
      logic [15:0] a, d;
      a = 16'(i * 16'h1357) ^ 16'hA5C3;
      d = {a[7:0], a[15:8]} ^ 16'(i << 4);
      build(DEST, ETYPE, 8'h01, a, d, 60, 1'b0);
      pulses = 0; send(0, 1'b0, 8);
      exp_w = 1'b1; exp_a = a; exp_d = d;
      expect_accept("R5 R6 R7 R10 write");
    end
    // R7: reads ignore data bytes
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = 16'hF000 >> (4 * i);
      build(DEST, ETYPE, 8'h00, a, 16'hBEEF, 60, 1'b0);
      pulses = 0; send(0, 1'b0, 8);
      exp_w = 1'b0; exp_a = a; exp_d = 16'h0000;
      expect_accept("R7 read zero data");
    end
    // R5: unknown codes
    for (int i = 0; i < 4; i++) begin
      logic [7:0] c;
      c = (i == 0) ? 8'h02 : (i == 1) ? 8'h03 : (i == 2) ? 8'h80 : 8'hFF;
      build(DEST, ETYPE, c, 16'h1111, 16'h2222, 60, 1'b0);
      pulses = 0; send(0, 1'b0, 8);
      expect_drop("R5 bad code");
    end
    // R3: one bit wrong in each destination byte
    for (int p = 0; p < 6; p++) begin
      build(DEST ^ (48'h1 << (8 * p + p)), ETYPE, 8'h01, 16'h3333, 16'h4444, 60, 1'b0);
      pulses = 0; send(0, 1'b0, 8);
      expect_drop("R3 dest mismatch");
    end
    // R4: wrong type
    build(DEST, 16'h88B4, 8'h01, 16'h5555, 16'h6666, 60, 1'b0);
    pulses = 0; send(0, 1'b0, 8); expect_drop("R4 type low byte");
    build(DEST, 16'h0800, 8'h01, 16'h5555, 16'h6666, 60, 1'b0);
    pulses = 0; send(0, 1'b0, 8); expect_drop("R4 type both bytes");
    // R8: corrupted check sequence
    build(DEST, ETYPE, 8'h01, 16'h7777, 16'h8888, 60, 1'b1);
    pulses = 0; send(0, 1'b0, 8); expect_drop("R8 bad fcs");
    // R9: length boundaries
    build(DEST, ETYPE, 8'h01, 16'h9999, 16'hAAAA, 19, 1'b0);
    pulses = 0; send(0, 1'b0, 8); expect_drop("R9 runt 23 bytes");
    build(DEST, ETYPE, 8'h01, 16'h9999, 16'hAAAA, 59, 1'b0);
    pulses = 0; send(0, 1'b0, 8); expect_drop("R9 63 bytes");
    build(DEST, ETYPE, 8'h01, 16'h0102, 16'h0304, 60, 1'b0);
    pulses = 0; send(0, 1'b0, 8);
    exp_w = 1'b1; exp_a = 16'h0102; exp_d = 16'h0304;
    expect_accept("R9 exactly 64 bytes");
    build(DEST, ETYPE, 8'h00, 16'h0506, 16'h0708, 140, 1'b0);
    pulses = 0; send(0, 1'b0, 8);
    exp_w = 1'b0; exp_a = 16'h0506; exp_d = 16'h0000;
    expect_accept("R9 long padding");
    build(DEST, ETYPE, 8'h01, 16'hCCCC, 16'hDDDD, 60, 1'b0);
    pulses = 0; send(0, 1'b1, 8); expect_drop("R9 partial byte");
    // R2: framing
    build(DEST, ETYPE, 8'h01, 16'hCAFE, 16'hF00D, 60, 1'b0);
    pulses = 0; send(1, 1'b0, 8); expect_drop("R2 no preamble");
    pulses = 0; send(2, 1'b0, 8); expect_drop("R2 no delimiter");
    // R10: back-to-back frames, short gap
    build(DEST, ETYPE, 8'h01, 16'h1234, 16'h5678, 60, 1'b0);
    pulses = 0; send(0, 1'b0, 2);
    build(DEST, ETYPE, 8'h01, 16'h4321, 16'h8765, 60, 1'b0);
    send(0, 1'b0, 8);
    chk(pulses == 2, "R10 back-to-back strobes", 32'(pulses), 32'd2);
    chk(cmd_addr == 16'h4321 && cmd_wdata == 16'h8765, "R11 last frame wins",
        {cmd_addr, cmd_wdata}, 32'h4321_8765);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule